// File: doc/BRIEF.md
# Partitioned Translation Buffer with Used-Bit Tracking

A fully associative translation buffer of up to 64 entries (16 by default). Each slot holds a naturally aligned virtual page with a size code, the partition and context it belongs to, a flag that marks the mapping as real (context-free), and a page descriptor. The descriptor carries a physical page number and five attribute bits: lock, privileged, writable, no-fault and side-effect. One command is accepted per cycle on a valid-qualified bus. Its response appears on the following clock edge together with `rsp_valid`.

The commands are:
- lookup, with an option that leaves the used bits untouched;
- insert at a given slot, or insert at a slot the block picks itself;
- removal of one page, of a whole context, or of a whole partition;
- invalidate-all;
- a diagnostic read that returns a slot's tag word and data word.

Every insert first clears any entry that overlaps the new page in the same address space. Automatic placement prefers the lowest free slot. Failing that, it walks forward from the slot it last replaced, looking for an unlocked entry. A used bit per slot records recent use, and the used bits are cleared as a group once they would all be set.

Top module: `nru_tlb`

## Requirements
- R1: `rsp_valid` is high in the cycle after every cycle with `cmd_valid` high, and low after every cycle without it.
- R2: A lookup (op 0) hits when a valid entry has the same real flag and partition, and also the same context unless the real flag is set, and its page covers `cmd_vpn`. A size code s covers 8^s base pages. The lowest matching index is returned. `rsp_ppn` takes its upper bits from the entry and the bits below the page size from `cmd_vpn`.
- R3: An insert stores the virtual page number aligned down to its page size.
- R4: Before an insert (op 1 automatic, op 2 at `cmd_index`), every valid entry in the same address space whose page overlaps the new page is invalidated.
- R5: Automatic insert takes the lowest invalid slot. If every slot is valid, it takes the first unlocked slot found by walking forward with wraparound from the last replaced slot, not counting that slot itself, and that slot becomes the new last replaced slot. After reset the last replaced slot is 0.
- R6: If automatic insert finds no free slot and no unlocked slot, it overwrites slot ENTRIES-1.
- R7: Insert and an updating lookup hit set the slot's used bit. When that leaves every slot used, all other used bits are cleared. The used bit reads back at data bit 7.
- R8: A lookup with `cmd_no_update` high changes no used bit.
- R9: Demap-page (op 3) invalidates the entry that the same key would hit. Demap-context (op 4) invalidates every entry with a matching partition and context. Demap-partition (op 5) invalidates the valid, unlocked entries of that partition. Invalidate-all (op 6) clears every entry.
- R10: A read (op 7) of an invalid slot returns all ones in both the tag word and the data word.
- R11: Tag word fields: context at bits 12:0, virtual page at bits 32:13, inverted size code at 57:56, real flag at bit 60, partition at 63:61. Data word fields: size at 1:0, lock at 2, privileged at 3, writable at 4, no-fault at 5, side-effect at 6, used at 7, physical page at 32:13.
- R12: After reset every slot is invalid and the count of used slots is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 lookup, 1 insert auto, 2 insert at index, 3 demap page, 4 demap context, 5 demap partition, 6 invalidate all, 7 read |
| cmd_index | input | IDX_W | Slot for explicit insert and read |
| cmd_vpn | input | 20 | Virtual page number |
| cmd_part | input | 3 | Partition id |
| cmd_ctx | input | 13 | Context id |
| cmd_real | input | 1 | Real (context-free) mapping |
| cmd_size | input | 2 | Page size code |
| cmd_ppn | input | 20 | Physical page number to insert |
| cmd_lock | input | 1 | Lock attribute to insert |
| cmd_priv | input | 1 | Privileged attribute to insert |
| cmd_writable | input | 1 | Writable attribute to insert |
| cmd_nofault | input | 1 | No-fault attribute to insert |
| cmd_sidefx | input | 1 | Side-effect attribute to insert |
| cmd_no_update | input | 1 | Lookup leaves used bits unchanged |
| rsp_valid | output | 1 | Response for previous cycle's command |
| rsp_hit | output | 1 | Lookup hit |
| rsp_index | output | IDX_W | Hit slot, or slot written by insert |
| rsp_ppn | output | 20 | Translated physical page |
| rsp_priv | output | 1 | Hit entry privileged |
| rsp_writable | output | 1 | Hit entry writable |
| rsp_nofault | output | 1 | Hit entry no-fault |
| rsp_sidefx | output | 1 | Hit entry side-effect |
| rsp_tag | output | 64 | Tag word of read |
| rsp_data | output | 64 | Data word of read |

## Verification
The hardest states to reach from the ports are a table with no free slot, both with every slot locked and with only a few slots unlocked, and the moment the last used bit is set. The stimulus reaches them by filling every slot through automatic inserts with a chosen lock pattern. It then issues further automatic inserts and checks that placement walks from the last replaced slot and skips locked entries. A fifteen-slot fill followed by one more insert triggers the group clear of the used bits. Non-updating and updating lookups are then compared through the used bit in the diagnostic data word.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W  = 20;
    localparam int PPN_W  = 20;
    localparam int PART_W = 3;
    localparam int CTX_W  = 13;
    localparam int SZ_W   = 2;
    // tag word positions
    localparam int TAG_VPN_LSB  = 13;
    localparam int TAG_SZ_LSB   = 56;
    localparam int TAG_REAL_BIT = 60;
    localparam int TAG_PART_LSB = 61;
    // data word positions
    localparam int DAT_PPN_LSB  = 13;

    typedef enum logic [2:0] {
        OP_LOOKUP    = 3'd0,
        OP_INS_AUTO  = 3'd1,
        OP_INS_IDX   = 3'd2,
        OP_DMP_PAGE  = 3'd3,
        OP_DMP_CTX   = 3'd4,
        OP_DMP_PART  = 3'd5,
        OP_INV_ALL   = 3'd6,
        OP_READ      = 3'd7
    } op_e;

    typedef struct packed {
        logic              valid;
        logic              used;
        logic              real_pg;
        logic [PART_W-1:0] part;
        logic [CTX_W-1:0]  ctx;
        logic [VPN_W-1:0]  vpn;
        logic [SZ_W-1:0]   sz;
        logic [PPN_W-1:0]  ppn;
        logic              lock;
        logic              priv;
        logic              wr;
        logic              nf;
        logic              se;
    } entry_t;

    typedef struct packed {
        logic              ack;
        logic              hit;
        logic [5:0]        idx;
        logic [PPN_W-1:0]  ppn;
        logic              priv;
        logic              wr;
        logic              nf;
        logic              se;
        logic [63:0]       tag;
        logic [63:0]       data;
    } rsp_t;

    // low-order page bits covered by a size code: 8^sz base pages
    function automatic logic [VPN_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
        logic [63:0] m;
        m = (64'd1 << (3 * int'(sz))) - 64'd1;
        return m[VPN_W-1:0];
    endfunction
endpackage

// File: rtl/tlb_prio.sv
module tlb_prio #(
    parameter int N    = 16,
    parameter int IW   = 4
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  entry_t             ent [N],
    input  logic [VPN_W-1:0]   k_vpn,
    input  logic [PART_W-1:0]  k_part,
    input  logic [CTX_W-1:0]   k_ctx,
    input  logic               k_real,
    input  logic [SZ_W-1:0]    k_sz,
    output logic [N-1:0]       lk_vec,
    output logic [N-1:0]       ov_vec,
    output logic [N-1:0]       cx_vec,
    output logic [N-1:0]       pt_vec
);
    logic [VPN_W-1:0] kmask;
    assign kmask = page_mask(k_sz);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic             same_space;
        logic [VPN_W-1:0] emask;
        logic [VPN_W-1:0] diff;
        assign emask      = page_mask(ent[g].sz);
        assign diff       = ent[g].vpn ^ k_vpn;
        assign same_space = ent[g].valid && (ent[g].real_pg == k_real) &&
                            (ent[g].part == k_part) &&
                            (k_real || (ent[g].ctx == k_ctx));
        assign lk_vec[g]  = same_space && ((diff & ~emask) == '0);
        assign ov_vec[g]  = same_space && ((diff & ~(emask | kmask)) == '0);
        assign cx_vec[g]  = ent[g].valid && (ent[g].part == k_part) &&
                            (ent[g].ctx == k_ctx);
        assign pt_vec[g]  = ent[g].valid && !ent[g].lock &&
                            (ent[g].part == k_part);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  lock,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] victim,
    output logic          scanned
);
    logic          free_found;
    logic [IW-1:0] free_idx;

    tlb_prio #(.N(N), .IW(IW)) u_free (
        .vec   (~valid),
        .found (free_found),
        .idx   (free_idx)
    );

    always_comb begin
        logic          hit;
        logic [IW-1:0] pick;
        hit  = 1'b0;
        pick = IW'(N - 1);
        // descending offset so the nearest slot after last wins
        for (int k = N - 1; k >= 1; k--) begin
            int j;
            j = (int'(last) + k) % N;
            if (!lock[j]) begin
                hit  = 1'b1;
                pick = IW'(j);
            end
        end
        if (free_found) begin
            victim  = free_idx;
            scanned = 1'b0;
        end else begin
            victim  = pick;
            scanned = hit;
        end
    end
endmodule

// File: rtl/nru_tlb.sv
module nru_tlb
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 16,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [VPN_W-1:0]  cmd_vpn,
    input  logic [PART_W-1:0] cmd_part,
    input  logic [CTX_W-1:0]  cmd_ctx,
    input  logic              cmd_real,
    input  logic [SZ_W-1:0]   cmd_size,
    input  logic [PPN_W-1:0]  cmd_ppn,
    input  logic              cmd_lock,
    input  logic              cmd_priv,
    input  logic              cmd_writable,
    input  logic              cmd_nofault,
    input  logic              cmd_sidefx,
    input  logic              cmd_no_update,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_index,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              rsp_priv,
    output logic              rsp_writable,
    output logic              rsp_nofault,
    output logic              rsp_sidefx,
    output logic [63:0]       rsp_tag,
    output logic [63:0]       rsp_data
);
    entry_t             ent_q [ENTRIES];
    entry_t             ent_d [ENTRIES];
    logic [IDX_W-1:0]   last_q, last_d;
    logic [CNT_W-1:0]   used_cnt_q, used_cnt_d;
    rsp_t               rsp_q, rsp_d;

    logic [ENTRIES-1:0] lk_vec, ov_vec, cx_vec, pt_vec;
    logic [ENTRIES-1:0] valid_vec, lock_vec;
    logic               lk_found;
    logic [IDX_W-1:0]   lk_idx, vic_idx, tgt;
    logic               vic_scan, set_used;
    op_e                op;

    assign op = op_e'(cmd_op);

    tlb_match #(.N(ENTRIES)) u_match (
        .ent    (ent_q),
        .k_vpn  (cmd_vpn),
        .k_part (cmd_part),
        .k_ctx  (cmd_ctx),
        .k_real (cmd_real),
        .k_sz   (cmd_size),
        .lk_vec (lk_vec),
        .ov_vec (ov_vec),
        .cx_vec (cx_vec),
        .pt_vec (pt_vec)
    );

    tlb_prio #(.N(ENTRIES), .IW(IDX_W)) u_hit (
        .vec   (lk_vec),
        .found (lk_found),
        .idx   (lk_idx)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
        assign valid_vec[g] = ent_q[g].valid && !ov_vec[g];
        assign lock_vec[g]  = ent_q[g].lock;
    end

    tlb_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
        .valid   (valid_vec),
        .lock    (lock_vec),
        .last    (last_q),
        .victim  (vic_idx),
        .scanned (vic_scan)
    );

    always_comb begin
        entry_t           e;
        logic [VPN_W-1:0] m;
        logic [CNT_W-1:0] cnt;
        ent_d    = ent_q;
        last_d   = last_q;
        rsp_d    = '0;
        rsp_d.ack = cmd_valid;
        set_used = 1'b0;
        tgt      = '0;
        e        = ent_q[lk_idx];
        m        = page_mask(e.sz);
        if (cmd_valid) begin
            unique case (op)
                OP_LOOKUP: if (lk_found) begin
                    rsp_d.hit  = 1'b1;
                    rsp_d.idx  = 6'(lk_idx);
                    rsp_d.ppn  = (e.ppn & ~PPN_W'(m)) | PPN_W'(cmd_vpn & m);
                    rsp_d.priv = e.priv;
                    rsp_d.wr   = e.wr;
                    rsp_d.nf   = e.nf;
                    rsp_d.se   = e.se;
                    if (!cmd_no_update && !e.used) begin
                        ent_d[lk_idx].used = 1'b1;
                        set_used = 1'b1;
                        tgt      = lk_idx;
                    end
                end
                OP_INS_AUTO, OP_INS_IDX: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (ov_vec[i]) ent_d[i] = '0;
                    tgt = (op == OP_INS_AUTO) ? vic_idx : cmd_index;
                    if (op == OP_INS_AUTO && vic_scan) last_d = vic_idx;
                    if (int'(tgt) < ENTRIES) begin
                        ent_d[tgt] = '{valid: 1'b1, used: 1'b1, real_pg: cmd_real,
                                       part: cmd_part, ctx: cmd_ctx,
                                       vpn: cmd_vpn & ~page_mask(cmd_size),
                                       sz: cmd_size, ppn: cmd_ppn, lock: cmd_lock,
                                       priv: cmd_priv, wr: cmd_writable,
                                       nf: cmd_nofault, se: cmd_sidefx};
                        set_used = 1'b1;
                    end
                    rsp_d.idx = 6'(tgt);
                end
                OP_DMP_PAGE: if (lk_found) ent_d[lk_idx] = '0;
                OP_DMP_CTX:
                    for (int i = 0; i < ENTRIES; i++)
                        if (cx_vec[i]) ent_d[i] = '0;
                OP_DMP_PART:
                    for (int i = 0; i < ENTRIES; i++)
                        if (pt_vec[i]) ent_d[i] = '0;
                OP_INV_ALL:
                    for (int i = 0; i < ENTRIES; i++) ent_d[i] = '0;
                OP_READ: begin
                    rsp_d.tag  = '1;
                    rsp_d.data = '1;
                    if (int'(cmd_index) < ENTRIES && ent_q[cmd_index].valid) begin
                        e = ent_q[cmd_index];
                        rsp_d.tag  = '0;
                        rsp_d.data = '0;
                        rsp_d.tag[CTX_W-1:0]                = e.ctx;
                        rsp_d.tag[TAG_VPN_LSB +: VPN_W]     = e.vpn;
                        rsp_d.tag[TAG_SZ_LSB +: SZ_W]       = ~e.sz;
                        rsp_d.tag[TAG_REAL_BIT]             = e.real_pg;
                        rsp_d.tag[TAG_PART_LSB +: PART_W]   = e.part;
                        rsp_d.data[SZ_W-1:0]                = e.sz;
                        rsp_d.data[7:2] = {e.used, e.se, e.nf, e.wr, e.priv, e.lock};
                        rsp_d.data[DAT_PPN_LSB +: PPN_W]    = e.ppn;
                    end
                end
                default: ;
            endcase
        end
        cnt = '0;
        for (int i = 0; i < ENTRIES; i++)
            cnt = cnt + CNT_W'(ent_d[i].used);
        if (set_used && int'(cnt) == ENTRIES) begin
            for (int i = 0; i < ENTRIES; i++)
                if (IDX_W'(i) != tgt) ent_d[i].used = 1'b0;
            cnt = CNT_W'(1);
        end
        used_cnt_d = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
            last_q     <= '0;
            used_cnt_q <= '0;
            rsp_q      <= '0;
        end else begin
            ent_q      <= ent_d;
            last_q     <= last_d;
            used_cnt_q <= used_cnt_d;
            rsp_q      <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.ack;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_index    = rsp_q.idx[IDX_W-1:0];
    assign rsp_ppn      = rsp_q.ppn;
    assign rsp_priv     = rsp_q.priv;
    assign rsp_writable = rsp_q.wr;
    assign rsp_nofault  = rsp_q.nf;
    assign rsp_sidefx   = rsp_q.se;
    assign rsp_tag      = rsp_q.tag;
    assign rsp_data     = rsp_q.data;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter  int ENTRIES = 16,
    localparam int CNT_W   = $clog2(ENTRIES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             cmd_no_update,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [63:0]      rsp_tag,
    input logic [63:0]      rsp_data,
    input logic [CNT_W-1:0] used_cnt
);
    initial begin
        p_entries_range: assert (ENTRIES >= 2 && ENTRIES <= 64);
    end

    p_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    p_hit_from_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ($past(cmd_valid) && $past(cmd_op) == 3'd0));

    p_used_never_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        used_cnt < CNT_W'(ENTRIES));

    p_no_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0 && cmd_no_update) |=> $stable(used_cnt));

    p_invalid_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_tag == '1) |-> rsp_data == '1);
endmodule

bind nru_tlb tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_no_update (cmd_no_update),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_tag       (rsp_tag),
    .rsp_data      (rsp_data),
    .used_cnt      (used_cnt_q)
);

// File: tb/test_nru_tlb.sv
module test_nru_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_index = '0;
    logic [19:0] cmd_vpn = '0;
    logic [2:0]  cmd_part = '0;
    logic [12:0] cmd_ctx = '0;
    logic        cmd_real = 1'b0;
    logic [1:0]  cmd_size = '0;
    logic [19:0] cmd_ppn = '0;
    logic        cmd_lock = 1'b0, cmd_priv = 1'b0, cmd_writable = 1'b0;
    logic        cmd_nofault = 1'b0, cmd_sidefx = 1'b0, cmd_no_update = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_priv, rsp_writable, rsp_nofault, rsp_sidefx;
    logic [3:0]  rsp_index;
    logic [19:0] rsp_ppn;
    logic [63:0] rsp_tag, rsp_data;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    nru_tlb #(.ENTRIES(16)) i_nru_tlb (.*);

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  idx;
        logic [19:0] vpn;
        logic [2:0]  part;
        logic [12:0] ctx;
        logic        rl;
        logic [1:0]  sz;
        logic [19:0] ppn;
        logic        hit;
        logic [3:0]  eidx;
        logic [19:0] eppn;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{3'd2, 4'd2, 20'h00105, 3'd1, 13'd7,  1'b0, 2'd0, 20'h0AAAA, 1'b0, 4'd2, 20'h0},
        '{3'd0, 4'd0, 20'h00105, 3'd1, 13'd7,  1'b0, 2'd0, 20'h0,     1'b1, 4'd2, 20'h0AAAA},
        '{3'd0, 4'd0, 20'h00105, 3'd1, 13'd8,  1'b0, 2'd0, 20'h0,     1'b0, 4'd0, 20'h0},
        '{3'd0, 4'd0, 20'h00105, 3'd2, 13'd7,  1'b0, 2'd0, 20'h0,     1'b0, 4'd0, 20'h0},
        '{3'd2, 4'd5, 20'h00213, 3'd1, 13'd7,  1'b0, 2'd1, 20'h0BBB0, 1'b0, 4'd5, 20'h0},
        '{3'd0, 4'd0, 20'h00217, 3'd1, 13'd7,  1'b0, 2'd0, 20'h0,     1'b1, 4'd5, 20'h0BBB7},
        '{3'd0, 4'd0, 20'h00218, 3'd1, 13'd7,  1'b0, 2'd0, 20'h0,     1'b0, 4'd0, 20'h0},
        '{3'd2, 4'd3, 20'h00300, 3'd1, 13'd0,  1'b1, 2'd0, 20'h01234, 1'b0, 4'd3, 20'h0},
        '{3'd0, 4'd0, 20'h00300, 3'd1, 13'd99, 1'b1, 2'd0, 20'h0,     1'b1, 4'd3, 20'h01234},
        '{3'd0, 4'd0, 20'h00300, 3'd1, 13'd0,  1'b0, 2'd0, 20'h0,     1'b0, 4'd0, 20'h0}
    };

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [3:0] idx,
                         input logic [19:0] vpn, input logic [2:0] part,
                         input logic [12:0] ctx, input logic rl,
                         input logic [1:0] sz, input logic [19:0] ppn,
                         input logic lk, input logic nu);
        @(negedge clk);
        cmd_op = op; cmd_index = idx; cmd_vpn = vpn; cmd_part = part;
        cmd_ctx = ctx; cmd_real = rl; cmd_size = sz; cmd_ppn = ppn;
        cmd_lock = lk; cmd_no_update = nu; cmd_priv = 1'b1; cmd_writable = 1'b0;
        cmd_nofault = 1'b0; cmd_sidefx = 1'b1;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx);
        issue(3'd7, idx, '0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic chk_gone(input logic [3:0] idx, input string req);
        rd(idx);
        chk(rsp_tag == '1 && rsp_data == '1, req, rsp_tag, '1);
    endtask

    task automatic chk_live(input logic [3:0] idx, input string req);
        rd(idx);
        chk(rsp_tag != '1, req, rsp_tag, 64'h0);
    endtask

    task automatic chk_used(input logic [3:0] idx, input logic exp, input string req);
        rd(idx);
        chk(rsp_data[7] == exp, req, 64'(rsp_data[7]), 64'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        logic [63:0] exp;
        repeat (3) @(negedge clk);
        // R12 / R1: reset state
        chk(rsp_valid == 1'b0, "R1 idle after reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        chk_gone(4'd0, "R12 slot 0 invalid after reset");
        chk_gone(4'd15, "R10 read invalid slot all ones");

        // table walk: R2, R3 lookups and explicit inserts
        foreach (VEC[i]) begin
            issue(VEC[i].op, VEC[i].idx, VEC[i].vpn, VEC[i].part, VEC[i].ctx,
                  VEC[i].rl, VEC[i].sz, VEC[i].ppn, 1'b0, 1'b0);
            chk(rsp_valid, "R1 ack", 64'(rsp_valid), 64'd1);
            if (VEC[i].op == 3'd0) begin
                chk(rsp_hit == VEC[i].hit, "R2 hit", 64'(rsp_hit), 64'(VEC[i].hit));
                if (VEC[i].hit) begin
                    chk(rsp_index == VEC[i].eidx, "R2 index", 64'(rsp_index), 64'(VEC[i].eidx));
                    chk(rsp_ppn == VEC[i].eppn, "R2 ppn", 64'(rsp_ppn), 64'(VEC[i].eppn));
                    chk(rsp_priv && rsp_sidefx && !rsp_writable && !rsp_nofault,
                        "R2 attrs", {60'd0, rsp_priv, rsp_writable, rsp_nofault, rsp_sidefx},
                        64'h9);
                end
            end else begin
                chk(rsp_index == VEC[i].eidx, "R3 insert slot", 64'(rsp_index), 64'(VEC[i].eidx));
            end
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 idle cycle", 64'(rsp_valid), 64'd0);

        // R3 / R11: tag and data layout of slot 5 (aligned 0x210, size 1)
        rd(4'd5);
        exp = (64'd1 << 61) | (64'd2 << 56) | (64'h210 << 13) | 64'd7;
        chk(rsp_tag == exp, "R3 R11 tag word", rsp_tag, exp);
        exp = (64'h0BBB0 << 13) | 64'h48 | 64'd1;
        chk((rsp_data & ~64'h80) == exp, "R11 data word", rsp_data & ~64'h80, exp);

        // R4: overlapping insert removes slot 5, other context keeps slot 2
        issue(3'd2, 4'd9, 20'h00214, 3'd1, 13'd7, 1'b0, 2'd0, 20'h00009, 1'b0, 1'b0);
        chk_gone(4'd5, "R4 overlap removed");
        issue(3'd2, 4'd10, 20'h00105, 3'd1, 13'd8, 1'b0, 2'd0, 20'h0000A, 1'b0, 1'b0);
        chk_live(4'd2, "R4 other context kept");

        // R9: demap page, context, partition, all
        issue(3'd3, 4'd0, 20'h00105, 3'd1, 13'd7, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        chk_gone(4'd2, "R9 demap page");
        chk_live(4'd10, "R9 demap page keeps other ctx");
        issue(3'd4, 4'd0, 20'h0, 3'd1, 13'd8, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        chk_gone(4'd10, "R9 demap context");
        issue(3'd2, 4'd11, 20'h00400, 3'd1, 13'd7, 1'b0, 2'd0, '0, 1'b1, 1'b0);
        issue(3'd2, 4'd12, 20'h00500, 3'd1, 13'd7, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        issue(3'd2, 4'd13, 20'h00600, 3'd2, 13'd7, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        issue(3'd5, 4'd0, 20'h0, 3'd1, 13'd0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        chk_live(4'd11, "R9 partition keeps locked");
        chk_gone(4'd12, "R9 partition removes unlocked");
        chk_live(4'd13, "R9 partition keeps other partition");
        chk_gone(4'd3, "R9 partition removes real entry");
        issue(3'd6, 4'd0, '0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
        chk_gone(4'd11, "R9 invalidate all locked");
        chk_gone(4'd13, "R9 invalidate all");

        // R5 / R6: fill locked, then all-locked fallback
        for (int k = 0; k < 16; k++) begin
            issue(3'd1, 4'd0, 20'h01000 + 20'(k), 3'd0, 13'd1, 1'b0, 2'd0, '0, 1'b1, 1'b0);
            chk(rsp_index == 4'(k), "R5 lowest free slot", 64'(rsp_index), 64'(k));
        end
        issue(3'd1, 4'd0, 20'h01F00, 3'd0, 13'd1, 1'b0, 2'd0, '0, 1'b1, 1'b0);
        chk(rsp_index == 4'd15, "R6 all locked uses last slot", 64'(rsp_index), 64'd15);

        // R5: scan with slots 4 and 9 unlocked
        issue(3'd6, 4'd0, '0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
        for (int k = 0; k < 16; k++)
            issue(3'd1, 4'd0, 20'h02000 + 20'(k), 3'd0, 13'd1, 1'b0, 2'd0, '0,
                  !(k == 4 || k == 9), 1'b0);
        issue(3'd1, 4'd0, 20'h02100, 3'd0, 13'd1, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        chk(rsp_index == 4'd4, "R5 scan first unlocked", 64'(rsp_index), 64'd4);
        issue(3'd1, 4'd0, 20'h02101, 3'd0, 13'd1, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        chk(rsp_index == 4'd9, "R5 scan from last replaced", 64'(rsp_index), 64'd9);
        issue(3'd1, 4'd0, 20'h02102, 3'd0, 13'd1, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        chk(rsp_index == 4'd4, "R5 scan wraps", 64'(rsp_index), 64'd4);

        // R7 / R8: used-bit group clear and non-updating lookup
        issue(3'd6, 4'd0, '0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
        for (int k = 0; k < 15; k++)
            issue(3'd1, 4'd0, 20'h03000 + 20'(k), 3'd0, 13'd1, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        chk_used(4'd0, 1'b1, "R7 insert sets used");
        issue(3'd1, 4'd0, 20'h0300F, 3'd0, 13'd1, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        chk_used(4'd0, 1'b0, "R7 group clear others");
        chk_used(4'd15, 1'b1, "R7 group clear keeps newest");
        issue(3'd0, 4'd0, 20'h03000, 3'd0, 13'd1, 1'b0, 2'd0, '0, 1'b0, 1'b1);
        chk(rsp_hit && rsp_index == 4'd0, "R8 lookup hit", 64'(rsp_index), 64'd0);
        chk_used(4'd0, 1'b0, "R8 no update keeps used clear");
        issue(3'd0, 4'd0, 20'h03000, 3'd0, 13'd1, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        chk_used(4'd0, 1'b1, "R7 updating lookup sets used");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule